// File: doc/BRIEF.md
# Parallel EPROM Mode Decoder Model

This block is a synthesizable behavioural model of a byte-wide parallel programmable read-only memory. A clock samples its control pins: an active-low chip enable, an active-low output enable and an active-low program strobe. It also samples two digital flags. One stands in for the high programming supply. The other stands in for the overvoltage that selects the identifier bytes. From these it picks one of seven modes: read, output disable, standby, program, program verify, program inhibit or signature. It then drives a byte-wide data bus together with an output-enable, which models the tri-state buffer.

The storage array is held in flip-flops. Reset fills the array with all ones, which is the fresh or erased state. Programming can only clear bits: each write ANDs the incoming byte into the stored byte. A write commits on the rising edge that ends a low program-strobe pulse. A synchronous clear input stands for ultraviolet erasure and returns every location to all ones. A parameter selects the one-time-programmable variant, and in that variant the clear input has no effect.

The address width is a parameter. The full part uses 14 bits (16384 bytes). The default is smaller so that the elaborated array stays modest.

Top module: `eprom_model`

## Requirements
- R1: After reset every location reads as 8'hFF in read mode.
- R2: Read mode is chip enable low, output enable low and the supply flag low, with the identifier flag low. In this mode the byte at the address drives the bus with the output-enable high, whatever the program strobe is. The outputs are registered, so they show the pins sampled at the previous rising clock edge.
- R3: With chip enable high the output-enable is low, whatever the other pins are.
- R4: With chip enable low and output enable high, the output-enable is low. This covers output disable, program and program inhibit.
- R5: A write commits when three things hold. First, the program strobe was low in the previous cycle with chip enable low, output enable high and the supply flag high. Second, the strobe is now high. Third, chip enable is still low, output enable is still high and the supply flag is still high. The stored byte becomes the old byte AND the data input, so a 0 bit never returns to 1.
- R6: Program verify is the supply flag high, chip enable low, output enable low and the program strobe high. In this mode the stored byte drives the bus.
- R7: A strobe pulse taken while chip enable is high, or while the supply flag is low, leaves the array unchanged. So does a strobe held high.
- R8: Signature mode is read mode with the identifier flag high. With address bit 0 at 0 it returns 8'h97, and with address bit 0 at 1 it returns 8'h83.
- R9: A clear pulse sets every location to 8'hFF when the erasable variant is selected (OTP = 0). When OTP = 1 the clear pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; fills the array with ones |
| addr_i | input | ADDR_W | Byte address |
| ce_n_i | input | 1 | Chip enable / power-down, active low |
| oe_n_i | input | 1 | Output enable, active low |
| pgm_n_i | input | 1 | Program strobe, active low |
| vpp_hi_i | input | 1 | Programming supply present |
| a9_hv_i | input | 1 | Identifier overvoltage present |
| dq_i | input | DATA_W | Data bus input (program data) |
| clear_i | input | 1 | Erase all locations to ones |
| dq_o | output | DATA_W | Data bus output value |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench uses a 64-byte configuration and sweeps every address. The sweeps run through four stages: the fresh state, a first program pass, a second overlapping pass, and the state after a clear. The second pass uses a pattern that sets bits the first pass had cleared, so only an AND update gives the expected bytes. A plain overwrite does not. All eight combinations of the other pins are tried with chip enable high, and the output-disable, program and inhibit states are checked for a released bus. The inhibit cases put a strobe pulse on a known byte with chip enable high, with the supply flag low, and with no pulse at all. An erasable instance and a one-time-programmable instance are driven side by side, so one clear pulse tells the two variants apart.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_READ,
        MODE_OUT_DIS,
        MODE_SIGNATURE,
        MODE_PROGRAM,
        MODE_VERIFY,
        MODE_INHIBIT
    } mode_e;

    localparam logic [7:0] ID_MAKER  = 8'h97;
    localparam logic [7:0] ID_DEVICE = 8'h83;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  ce_n_i,
    input  logic  oe_n_i,
    input  logic  pgm_n_i,
    input  logic  vpp_hi_i,
    input  logic  a9_hv_i,
    output mode_e mode_o
);

    always_comb begin
        mode_o = MODE_STANDBY;
        if (ce_n_i) begin
            mode_o = MODE_STANDBY;
        end else if (!vpp_hi_i) begin
            if (oe_n_i)       mode_o = MODE_OUT_DIS;
            else if (a9_hv_i) mode_o = MODE_SIGNATURE;
            else              mode_o = MODE_READ;
        end else begin
            if (oe_n_i && !pgm_n_i)      mode_o = MODE_PROGRAM;
            else if (!oe_n_i && pgm_n_i) mode_o = MODE_VERIFY;
            else                         mode_o = MODE_INHIBIT;
        end
    end

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter bit ERASABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              clear_eff;

    generate
        if (ERASABLE) begin : g_erasable
            assign clear_eff = clear_i;
        end else begin : g_otp
            assign clear_eff = 1'b0;
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (clear_eff) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] = '1;
            end
        end else if (wr_en_i) begin
            mem_d[wr_addr_i] = mem_q[wr_addr_i] & wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // R5: a committed write never leaves a 1 where the data had a 0
    assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !clear_i |=> ((mem_q[$past(wr_addr_i)] & ~$past(wr_data_i)) == '0));

    generate
        if (ERASABLE) begin : g_chk_erase
            // R9: after a clear every address reads all ones
            assert_erase_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
                clear_i |=> (rd_data_o == '1));
        end
    endgenerate

endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter bit OTP    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              pgm_n_i,
    input  logic              vpp_hi_i,
    input  logic              a9_hv_i,
    input  logic [DATA_W-1:0] dq_i,
    input  logic              clear_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);

    typedef struct packed {
        logic              armed;
        logic [DATA_W-1:0] dq;
        logic              oe;
    } bus_state_t;

    bus_state_t        st_d, st_q;
    mode_e             mode;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    eprom_mode_dec u_dec (
        .ce_n_i   (ce_n_i),
        .oe_n_i   (oe_n_i),
        .pgm_n_i  (pgm_n_i),
        .vpp_hi_i (vpp_hi_i),
        .a9_hv_i  (a9_hv_i),
        .mode_o   (mode)
    );

    eprom_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ERASABLE (!OTP)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .wr_en_i   (wr_en),
        .wr_addr_i (addr_i),
        .wr_data_i (dq_i),
        .rd_addr_i (addr_i),
        .rd_data_o (rd_data)
    );

    // commit on the strobe's rising edge, only if still enabled and powered
    assign wr_en = st_q.armed && vpp_hi_i && !ce_n_i && oe_n_i && pgm_n_i;

    always_comb begin
        st_d       = st_q;
        st_d.armed = (mode == MODE_PROGRAM);
        case (mode)
            MODE_READ, MODE_VERIFY: begin
                st_d.dq = rd_data;
                st_d.oe = 1'b1;
            end
            MODE_SIGNATURE: begin
                st_d.dq = addr_i[0] ? DATA_W'(ID_DEVICE) : DATA_W'(ID_MAKER);
                st_d.oe = 1'b1;
            end
            default: begin
                st_d.dq = '0;
                st_d.oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_o    = st_q.dq;
    assign dq_oe_o = st_q.oe;

    // R3: standby releases the bus
    assert_standby_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |=> !dq_oe_o);

    // R4: output enable high with chip enabled releases the bus
    assert_oe_high_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n_i && oe_n_i |=> !dq_oe_o);

    // R6: verify configuration drives the bus
    assert_verify_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_hi_i && !ce_n_i && !oe_n_i && pgm_n_i |=> dq_oe_o);

    // R8: signature with bit 0 low returns the maker byte
    assert_sig_maker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_hi_i && !ce_n_i && !oe_n_i && a9_hv_i && !addr_i[0]
        |=> dq_oe_o && (dq_o == DATA_W'(8'h97)));

    // R8: signature with bit 0 high returns the device byte
    assert_sig_device_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_hi_i && !ce_n_i && !oe_n_i && a9_hv_i && addr_i[0]
        |=> dq_oe_o && (dq_o == DATA_W'(8'h83)));

endmodule

// File: tb/eprom_model_tb_top.sv
module eprom_model_tb_top;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n, oe_n, pgm_n, vpp, a9, clr;
    logic [7:0]    din;
    logic [7:0]    dq_e, dq_p;
    logic          oe_e, oe_p;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    eprom_model #(.ADDR_W(AW), .DATA_W(8), .OTP(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
        .pgm_n_i(pgm_n), .vpp_hi_i(vpp), .a9_hv_i(a9), .dq_i(din), .clear_i(clr),
        .dq_o(dq_e), .dq_oe_o(oe_e)
    );

    eprom_model #(.ADDR_W(AW), .DATA_W(8), .OTP(1'b1)) dut_otp_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
        .pgm_n_i(pgm_n), .vpp_hi_i(vpp), .a9_hv_i(a9), .dq_i(din), .clear_i(clr),
        .dq_o(dq_p), .dq_oe_o(oe_p)
    );

    function automatic logic [7:0] pat1(int a);
        return 8'((a * 53 + 17) & 255);
    endfunction

    function automatic logic [7:0] pat2(int a);
        return 8'(((a * 29) & 255) ^ 8'hA5);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic pins(logic c, logic o, logic p, logic v, logic s, int a,
                        logic [7:0] d, logic e);
        ce_n = c; oe_n = o; pgm_n = p; vpp = v; a9 = s;
        addr = AW'(a); din = d; clr = e;
    endtask

    // read one address and compare both instances
    task automatic read_chk(string tag, int a, logic [7:0] exp_e,
                            logic [7:0] exp_p, logic pg);
        pins(0, 0, pg, 0, 0, a, 8'h00, 0);
        @(negedge clk);
        chk(tag, 8'(oe_e), 8'd1);
        chk(tag, dq_e, exp_e);
        chk(tag, dq_p, exp_p);
    endtask

    // strobe low one cycle, release, then verify
    task automatic program_byte(int a, logic [7:0] d);
        pins(0, 1, 0, 1, 0, a, d, 0);
        @(negedge clk);
        chk("R4 program hiz", 8'(oe_e), 8'd0);
        pins(0, 1, 1, 1, 0, a, d, 0);
        @(negedge clk);
        chk("R4 inhibit hiz", 8'(oe_e), 8'd0);
        model[a] = model[a] & d;
        pins(0, 0, 1, 1, 0, a, 8'h00, 0);
        @(negedge clk);
        chk("R6 verify oe", 8'(oe_e), 8'd1);
        chk("R5 R6 verify data", dq_e, model[a]);
        chk("R5 R6 verify otp", dq_p, model[a]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pins(1, 1, 1, 0, 0, 0, 8'h00, 0);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset hiz", 8'(oe_e), 8'd0);

        // R1 fresh contents, R2 with strobe toggled
        for (int a = 0; a < DEPTH; a++) read_chk("R1 R2 fresh read", a, 8'hFF, 8'hFF, a[0]);

        // R3 standby over all other pin combinations
        for (int k = 0; k < 8; k++) begin
            pins(1, k[0], k[1], k[2], 0, k, 8'h00, 0);
            @(negedge clk);
            chk("R3 standby hiz", 8'(oe_e), 8'd0);
        end

        // R4 output disable
        pins(0, 1, 1, 0, 0, 5, 8'h00, 0);
        @(negedge clk);
        chk("R4 output disable", 8'(oe_e), 8'd0);
        pins(0, 1, 0, 0, 0, 5, 8'h00, 0);
        @(negedge clk);
        chk("R4 output disable strobe low", 8'(oe_e), 8'd0);

        // R5 first pass, then overlapping pass (AND only)
        for (int a = 0; a < DEPTH; a++) program_byte(a, pat1(a));
        for (int a = 0; a < DEPTH; a++) read_chk("R2 read pass1", a, model[a], model[a], 1'b1);
        for (int a = 0; a < DEPTH; a++) program_byte(a, pat2(a));
        for (int a = 0; a < DEPTH; a++) begin
            read_chk("R5 clear-only", a, (pat1(a) & pat2(a)), (pat1(a) & pat2(a)), 1'b0);
        end

        // R7 inhibit cases on address 3 with all-zero data
        pins(1, 1, 0, 1, 0, 3, 8'h00, 0);
        @(negedge clk);
        pins(1, 1, 1, 1, 0, 3, 8'h00, 0);
        @(negedge clk);
        read_chk("R7 chip disabled pulse", 3, model[3], model[3], 1'b1);
        pins(0, 1, 0, 0, 0, 3, 8'h00, 0);
        @(negedge clk);
        pins(0, 1, 1, 0, 0, 3, 8'h00, 0);
        @(negedge clk);
        read_chk("R7 no supply pulse", 3, model[3], model[3], 1'b1);
        pins(0, 1, 1, 1, 0, 3, 8'h00, 0);
        repeat (4) @(negedge clk);
        read_chk("R7 strobe held high", 3, model[3], model[3], 1'b1);

        // R8 signature bytes, other address bits low
        pins(0, 0, 1, 0, 1, 0, 8'h00, 0);
        @(negedge clk);
        chk("R8 maker code", dq_e, 8'h97);
        chk("R8 maker oe", 8'(oe_e), 8'd1);
        pins(0, 0, 1, 0, 1, 1, 8'h00, 0);
        @(negedge clk);
        chk("R8 device code", dq_e, 8'h83);
        chk("R8 device code otp", dq_p, 8'h83);

        // R9 clear: erasable returns to ones, OTP keeps contents
        pins(1, 1, 1, 0, 0, 0, 8'h00, 1);
        @(negedge clk);
        for (int a = 0; a < DEPTH; a++) read_chk("R9 clear", a, 8'hFF, model[a], a[1]);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule